// File: doc/BRIEF.md
# Crypto Engine DMA Sequencer

This block runs one crypto operation end to end between a crypto engine and memory. A caller presents an operation descriptor: source address and byte length, destination address for cipher output, an address for the hash result, and separate cipher and hash enables. The sequencer writes the engine configuration, fires the engine start strobe, and then brings up two transfer channels. Each channel moves data only when the engine raises the matching flow-control request line.

Channel 1 first feeds input data from memory to the engine. When hashing is enabled, it then stores the hash result to memory. Channel 2 stores cipher output to memory and is used only when the cipher is enabled. Once every launched channel has drained, the sequencer reads the engine status word. It then reports completion with that word and an error flag.

The engine and memory sides are plain request/acknowledge ports. The cipher and hash algorithms are not part of this block.

Top module: `crypto_dma_seq`

## Requirements
- R1: After reset `op_ready` is 1 and `eng_cfg_valid`, `eng_go`, `ch1_req`, `ch2_req`, `eng_stat_rd` and `done` are 0.
- R2: An operation is accepted on a clock edge where `op_valid` and `op_ready` are both 1. `eng_cfg_valid` is high for exactly the next cycle, with `eng_cfg_word` = {cipher_en, hash_en, length}. `eng_go` is high for the cycle after that. No channel request is made before `eng_go`.
- R3: Channel 1 input phase: each `rq_in` pulse produces one burst request on channel 1 with `ch1_to_mem`=0. The address starts at the source address and advances by the previous burst length. The length is min(remaining, BURST), with BURST=16 by default. `ch1_req` is held, with stable fields, until `ch1_ack`.
- R4: With hash enabled, after the input bytes are exhausted, one `rq_hash` pulse produces a single channel 1 burst. That burst has `ch1_to_mem`=1, the hash address, and length HASH_BYTES (32 by default). With hash disabled, `rq_hash` never produces a channel 1 request.
- R5: With cipher enabled, each `rq_out` pulse produces one channel 2 burst. The address starts at the destination address and the length is min(remaining, BURST), following the same rules as R3.
- R6: With cipher disabled (hash-only included), channel 2 is never launched: `rq_out` pulses never produce `ch2_req`.
- R7: `eng_stat_rd` rises only after all launched channels have finished their bursts, and it is held until `eng_stat_ack`. `done` pulses for one cycle in the cycle after the acknowledge. At that point `done_status` equals the status word that was sampled.
- R8: `done_err` equals bit ERR_BIT of the sampled status (bit 0 by default).
- R9: `op_ready` is 0 from acceptance through the `done` cycle. An `op_valid` presented while busy is ignored and does not start an operation.
- R10: A length of 0 produces no input bursts and no output bursts. The operation still completes.
- R11: A request line pulsed while its channel phase is not active is ignored. This covers `rq_in` before launch and `rq_hash` during the input phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Idle, can accept an operation |
| op_src | input | AW | Source address of input data |
| op_len | input | LW | Byte length of input and cipher output |
| op_dst | input | AW | Cipher output address |
| op_hash_dst | input | AW | Hash result address |
| op_cipher | input | 1 | Cipher enable |
| op_hash | input | 1 | Hash enable |
| eng_cfg_valid | output | 1 | Engine configuration write strobe |
| eng_cfg_word | output | LW+2 | {cipher, hash, length} |
| eng_go | output | 1 | Engine start strobe |
| rq_in | input | 1 | Engine input-ready request |
| rq_out | input | 1 | Engine output-ready request |
| rq_hash | input | 1 | Engine hash-done request |
| ch1_req | output | 1 | Channel 1 burst request |
| ch1_addr | output | AW | Channel 1 memory address |
| ch1_len | output | LW | Channel 1 burst length |
| ch1_to_mem | output | 1 | 1 = engine to memory, 0 = memory to engine |
| ch1_ack | input | 1 | Channel 1 burst complete |
| ch2_req | output | 1 | Channel 2 burst request |
| ch2_addr | output | AW | Channel 2 memory address |
| ch2_len | output | LW | Channel 2 burst length |
| ch2_ack | input | 1 | Channel 2 burst complete |
| eng_stat_rd | output | 1 | Engine status read request |
| eng_stat_ack | input | 1 | Status word valid |
| eng_stat | input | SW | Engine status word |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Error flag with completion |
| done_status | output | SW | Status word with completion |

## Verification
The hardest situation to reach from the ports is a request line arriving while its channel sits in the wrong phase. One case is `rq_hash` while input bytes are still pending; another is `rq_in` in the cycle the start strobe is seen, before channel 1 is launched. The stimulus places these pulses in those exact cycles and confirms that no burst request follows. It also raises `op_valid` mid-operation and confirms that no configuration write appears afterwards. Table entries vary lengths around the burst size, with exact multiples, remainders and zero, across all enable combinations.

// File: rtl/crypto_dma_seq.sv
module crypto_dma_seq #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int SW = 8,
  parameter int BURST = 16,
  parameter int HASH_BYTES = 32,
  parameter int ERR_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [AW-1:0] op_src,
  input  logic [LW-1:0] op_len,
  input  logic [AW-1:0] op_dst,
  input  logic [AW-1:0] op_hash_dst,
  input  logic          op_cipher,
  input  logic          op_hash,
  output logic          eng_cfg_valid,
  output logic [LW+1:0] eng_cfg_word,
  output logic          eng_go,
  input  logic          rq_in,
  input  logic          rq_out,
  input  logic          rq_hash,
  output logic          ch1_req,
  output logic [AW-1:0] ch1_addr,
  output logic [LW-1:0] ch1_len,
  output logic          ch1_to_mem,
  input  logic          ch1_ack,
  output logic          ch2_req,
  output logic [AW-1:0] ch2_addr,
  output logic [LW-1:0] ch2_len,
  input  logic          ch2_ack,
  output logic          eng_stat_rd,
  input  logic          eng_stat_ack,
  input  logic [SW-1:0] eng_stat,
  output logic          done,
  output logic          done_err,
  output logic [SW-1:0] done_status
);
  localparam logic [LW-1:0] BLEN = LW'(BURST);
  localparam logic [LW-1:0] HLEN = LW'(HASH_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_GO, S_L1, S_L2, S_WAIT, S_STAT, S_FIN} st_t;
  st_t st;

  logic [AW-1:0] src_q, dst_q, hdst_q;
  logic [LW-1:0] len_q;
  logic          cip_q, hsh_q;
  logic [SW-1:0] stat_q;

  logic          c1_on, c1_ph;
  logic [AW-1:0] c1_addr;
  logic [LW-1:0] c1_rem, c1_blen;
  logic          c2_on;
  logic [AW-1:0] c2_addr;
  logic [LW-1:0] c2_rem, c2_blen;
  logic          c1_rq;

  assign op_ready      = (st == S_IDLE);
  assign eng_cfg_valid = (st == S_SETUP);
  assign eng_cfg_word  = {cip_q, hsh_q, len_q};
  assign eng_go        = (st == S_GO);
  assign eng_stat_rd   = (st == S_STAT);
  assign done          = (st == S_FIN);
  assign done_status   = stat_q;
  assign done_err      = stat_q[ERR_BIT];

  assign c1_blen    = c1_ph ? c1_rem : ((c1_rem < BLEN) ? c1_rem : BLEN);
  assign c2_blen    = (c2_rem < BLEN) ? c2_rem : BLEN;
  assign c1_rq      = c1_ph ? rq_hash : rq_in;
  assign ch1_addr   = c1_addr;
  assign ch1_len    = c1_blen;
  assign ch1_to_mem = c1_ph;
  assign ch2_addr   = c2_addr;
  assign ch2_len    = c2_blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_q <= '0; dst_q <= '0; hdst_q <= '0; len_q <= '0;
      cip_q <= 1'b0; hsh_q <= 1'b0; stat_q <= '0;
    end else begin
      case (st)
        S_IDLE:  if (op_valid) begin
                   st <= S_SETUP;
                   src_q <= op_src; dst_q <= op_dst; hdst_q <= op_hash_dst;
                   len_q <= op_len; cip_q <= op_cipher; hsh_q <= op_hash;
                 end
        S_SETUP: st <= S_GO;
        S_GO:    st <= S_L1;
        S_L1:    st <= S_L2;
        S_L2:    st <= S_WAIT;
        S_WAIT:  if (!c1_on && !c2_on) st <= S_STAT;
        S_STAT:  if (eng_stat_ack) begin
                   stat_q <= eng_stat;
                   st <= S_FIN;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_on <= 1'b0; c1_ph <= 1'b0; c1_addr <= '0; c1_rem <= '0; ch1_req <= 1'b0;
    end else if (st == S_L1) begin
      c1_on <= 1'b1; c1_ph <= 1'b0; c1_addr <= src_q; c1_rem <= len_q; ch1_req <= 1'b0;
    end else if (ch1_req) begin
      if (ch1_ack) begin
        ch1_req <= 1'b0;
        c1_addr <= c1_addr + AW'(c1_blen);
        c1_rem  <= c1_rem - c1_blen;
      end
    end else if (c1_on) begin
      if (c1_rem == '0) begin
        if (!c1_ph && hsh_q) begin
          c1_ph <= 1'b1; c1_addr <= hdst_q; c1_rem <= HLEN;
        end else begin
          c1_on <= 1'b0;
        end
      end else if (c1_rq) begin
        ch1_req <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_on <= 1'b0; c2_addr <= '0; c2_rem <= '0; ch2_req <= 1'b0;
    end else if (st == S_L2) begin
      c2_on <= cip_q; c2_addr <= dst_q; c2_rem <= len_q; ch2_req <= 1'b0;
    end else if (ch2_req) begin
      if (ch2_ack) begin
        ch2_req <= 1'b0;
        c2_addr <= c2_addr + AW'(c2_blen);
        c2_rem  <= c2_rem - c2_blen;
      end
    end else if (c2_on) begin
      if (c2_rem == '0) c2_on <= 1'b0;
      else if (rq_out)  ch2_req <= 1'b1;
    end
  end

  a_r2_go_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> $past(eng_cfg_valid));
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_req && !ch1_ack) |=> (ch1_req && $stable(ch1_addr) && $stable(ch1_len)));
  a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_req |-> (ch2_len != '0 && ch2_len <= BLEN));
  a_r6_no_ch2_hashonly: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_req |-> eng_cfg_word[LW+1]);
  a_r7_stat_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(eng_stat_rd && eng_stat_ack) && !ch1_req && !ch2_req));
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_req || ch2_req || eng_go) |-> !op_ready);
endmodule

// File: tb/crypto_dma_seq_bench.sv
module crypto_dma_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic op_valid = 0, op_cipher = 0, op_hash = 0;
  logic [31:0] op_src = 0, op_dst = 0, op_hash_dst = 0;
  logic [15:0] op_len = 0;
  logic rq_in = 0, rq_out = 0, rq_hash = 0, ch1_ack = 0, ch2_ack = 0, eng_stat_ack = 0;
  logic [7:0] eng_stat = 0;
  logic op_ready, eng_cfg_valid, eng_go, ch1_req, ch1_to_mem, ch2_req, eng_stat_rd, done, done_err;
  logic [17:0] eng_cfg_word;
  logic [31:0] ch1_addr, ch2_addr;
  logic [15:0] ch1_len, ch2_len;
  logic [7:0] done_status;

  crypto_dma_seq u_crypto_dma_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_src(op_src), .op_len(op_len), .op_dst(op_dst), .op_hash_dst(op_hash_dst),
    .op_cipher(op_cipher), .op_hash(op_hash), .eng_cfg_valid(eng_cfg_valid),
    .eng_cfg_word(eng_cfg_word), .eng_go(eng_go), .rq_in(rq_in), .rq_out(rq_out),
    .rq_hash(rq_hash), .ch1_req(ch1_req), .ch1_addr(ch1_addr), .ch1_len(ch1_len),
    .ch1_to_mem(ch1_to_mem), .ch1_ack(ch1_ack), .ch2_req(ch2_req), .ch2_addr(ch2_addr),
    .ch2_len(ch2_len), .ch2_ack(ch2_ack), .eng_stat_rd(eng_stat_rd),
    .eng_stat_ack(eng_stat_ack), .eng_stat(eng_stat), .done(done), .done_err(done_err),
    .done_status(done_status));

  typedef struct packed {
    logic [31:0] src;
    logic [15:0] len;
    logic [31:0] dst;
    logic [31:0] hsh;
    logic        cen;
    logic        hen;
    logic [7:0]  st;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0000_1000, 16'd40, 32'h0000_2000, 32'h0000_3000, 1'b1, 1'b0, 8'h10},
    '{32'h0000_4000, 16'd32, 32'h0000_4800, 32'h0000_5000, 1'b0, 1'b1, 8'h01},
    '{32'h0000_6000, 16'd20, 32'h0000_7000, 32'h0000_8000, 1'b1, 1'b1, 8'h81},
    '{32'h0000_9000, 16'd16, 32'h0000_A000, 32'h0000_B000, 1'b1, 1'b1, 8'h00},
    '{32'h0000_C000, 16'd0,  32'h0000_D000, 32'h0000_E000, 1'b1, 1'b0, 8'h02},
    '{32'h0000_F000, 16'd5,  32'h0001_0000, 32'h0001_1000, 1'b0, 1'b0, 8'h00}
  };

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // rsel: 0 = input phase, 1 = hash phase, 2 = output channel
  task automatic burst(input int rsel, input logic [31:0] eaddr, input int elen, input string tag);
    @(negedge clk);
    check("R7 status read held off while bursts remain", eng_stat_rd, 0);
    if (rsel == 0) rq_in = 1; else if (rsel == 1) rq_hash = 1; else rq_out = 1;
    @(negedge clk);
    rq_in = 0; rq_hash = 0; rq_out = 0;
    if (rsel == 2) begin
      check({tag, " req"}, ch2_req, 1);
      check({tag, " addr"}, ch2_addr, eaddr);
      check({tag, " len"}, ch2_len, elen);
      ch2_ack = 1;
    end else begin
      check({tag, " req"}, ch1_req, 1);
      check({tag, " addr"}, ch1_addr, eaddr);
      check({tag, " len"}, ch1_len, elen);
      check({tag, " dir"}, ch1_to_mem, (rsel == 1));
      @(negedge clk);
      check({tag, " held"}, ch1_req, 1);
      ch1_ack = 1;
    end
    @(negedge clk);
    ch1_ack = 0; ch2_ack = 0;
  endtask

  task automatic run_op(input vec_t v);
    int rem;
    logic [31:0] a;
    @(negedge clk);
    check("R9 ready before op", op_ready, 1);
    op_src = v.src; op_len = v.len; op_dst = v.dst; op_hash_dst = v.hsh;
    op_cipher = v.cen; op_hash = v.hen; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
    check("R2 cfg strobe", eng_cfg_valid, 1);
    check("R2 cfg word", eng_cfg_word, {v.cen, v.hen, v.len});
    check("R2 no go yet", eng_go, 0);
    check("R9 busy after accept", op_ready, 0);
    @(negedge clk);
    check("R2 go strobe", eng_go, 1);
    check("R2 cfg single cycle", eng_cfg_valid, 0);
    check("R2 no channel before go", ch1_req, 0);
    rq_in = 1;
    @(negedge clk);
    rq_in = 0;
    check("R2 go single cycle", eng_go, 0);
    @(negedge clk);
    check("R11 early rq_in ignored", ch1_req, 0);
    if (v.hen && v.len != 0) begin
      rq_hash = 1;
      @(negedge clk);
      rq_hash = 0;
      @(negedge clk);
      check("R11 rq_hash in input phase ignored", ch1_req, 0);
    end
    op_valid = 1; op_len = 16'd3;
    @(negedge clk);
    check("R9 refuse while busy", op_ready, 0);
    @(negedge clk);
    op_valid = 0;
    rem = v.len; a = v.src;
    while (rem > 0) begin
      int bl = (rem < 16) ? rem : 16;
      burst(0, a, bl, "R3 input burst");
      a += bl; rem -= bl;
    end
    if (v.len == 0) check("R10 no input burst", ch1_req, 0);
    if (v.cen) begin
      rem = v.len; a = v.dst;
      while (rem > 0) begin
        int bl = (rem < 16) ? rem : 16;
        burst(2, a, bl, "R5 output burst");
        a += bl; rem -= bl;
      end
      if (v.len == 0) check("R10 no output burst", ch2_req, 0);
    end else begin
      @(negedge clk); rq_out = 1;
      @(negedge clk); rq_out = 0;
      check("R6 no channel 2 request", ch2_req, 0);
      @(negedge clk);
      check("R6 no channel 2 request later", ch2_req, 0);
    end
    if (v.hen) begin
      @(negedge clk);
      burst(1, v.hsh, 32, "R4 hash burst");
    end else begin
      @(negedge clk); rq_hash = 1;
      @(negedge clk); rq_hash = 0;
      check("R4 no hash burst when disabled", ch1_req, 0);
    end
    for (int i = 0; i < 10 && !eng_stat_rd; i++) @(negedge clk);
    check("R7 status read raised", eng_stat_rd, 1);
    check("R7 no done before status", done, 0);
    @(negedge clk);
    check("R7 status read held", eng_stat_rd, 1);
    eng_stat = v.st; eng_stat_ack = 1;
    @(negedge clk);
    eng_stat_ack = 0; eng_stat = 8'hEE;
    check("R7 done pulse", done, 1);
    check("R7 done status", done_status, v.st);
    check("R8 error flag", done_err, v.st[0]);
    check("R9 not ready in done cycle", op_ready, 0);
    @(negedge clk);
    check("R7 done single cycle", done, 0);
    check("R9 ready after done", op_ready, 1);
    @(negedge clk);
    check("R9 busy request not started", eng_cfg_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", op_ready, 1);
    check("R1 cfg", eng_cfg_valid, 0);
    check("R1 go", eng_go, 0);
    check("R1 ch1", ch1_req, 0);
    check("R1 ch2", ch2_req, 0);
    check("R1 stat", eng_stat_rd, 0);
    check("R1 done", done, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after release", op_ready, 1);
    for (int k = 0; k < 6; k++) run_op(VEC[k]);
    // Directed: request pulses while idle have no effect
    @(negedge clk); rq_in = 1; rq_out = 1; rq_hash = 1;
    @(negedge clk); rq_in = 0; rq_out = 0; rq_hash = 0;
    @(negedge clk);
    check("R11 idle ch1 quiet", ch1_req, 0);
    check("R11 idle ch2 quiet", ch2_req, 0);
    check("R1 idle ready", op_ready, 1);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule